// File: doc/BRIEF.md
# Potentiometer SPI Command Decoder

This block is the serial front end of a four-channel digital potentiometer controller. It watches a mode-0 SPI link (clock idle low, input sampled on the rising clock edge, output changed on the falling edge) through a fast system clock. It decodes each frame into commands for the register-file block that holds the wiper and stored-setting registers. A frame begins when chip select falls. The first byte is an address byte. Its upper nibble must carry the fixed device type 0101, the next two bits must be zero, and the lowest two bits must equal the pin-strapped `dev_addr`. The second byte is the instruction.

Transfer instructions are complete after two bytes. Write instructions carry a third byte from the host. Read instructions return a third byte on `spi_so`, with `spi_so_oe` marking when the pin is driven. The step instruction opens an unbounded stream: every later clock pulse moves the selected wiper one position, up or down. An active-low pause input freezes the frame without losing its progress.

Commands leave on a valid/ready channel. `cmd_valid` stays high, with a stable payload, until `cmd_ready` is seen high on a clock edge. The decoder has one output slot. A command produced while that slot is still occupied is discarded, so the consumer must accept each command within one SPI bit time. Read data is fetched over a plain combinational lookup: `rd_pot`, `rd_sel` and `rd_wiper` select the register, and `rd_data` returns its value.

Top module: `potctl_spi_decoder`

## Requirements
- R1: After reset `cmd_valid` and `spi_so_oe` are low. No frame is decoded until `spi_csn` has been seen going from high to low; bits clocked while chip select has been low since reset produce nothing.
- R2: The first byte, sent MSB first, must equal {4'b0101, 2'b00, dev_addr[1:0]}. On any mismatch the frame produces no command and `spi_so_oe` stays low.
- R3: In the second byte, bits 7:4 hold the opcode, bits 3:2 the register select and bits 1:0 the pot select. These fields are copied to `cmd_sel` and `cmd_pot`.
- R4: The transfer opcodes each issue one command when chip select rises after exactly 16 bits: 1101 gives kind 2 (stored to wiper), 1110 gives kind 3 (wiper to stored), 0001 gives kind 4 (global stored to wiper) and 1000 gives kind 5 (global wiper to stored).
- R5: The write opcodes issue one command, with the third byte in `cmd_data`, when chip select rises after exactly 24 bits: 1010 gives kind 0 (wiper write) and 1100 gives kind 1 (stored register write).
- R6: The read opcodes are 1001 (wiper of pot `rd_pot`, `rd_wiper`=1) and 1011 (stored register `rd_sel` of pot `rd_pot`). For these, `rd_data` is captured once the second byte completes. It is shifted out MSB first on `spi_so`, one bit per falling clock edge, starting with the first falling edge after bit 16. `spi_so_oe` is never high before 16 bits have been received.
- R7: Opcode 0101 returns the byte {7'b0, wr_busy} in the same way as R6.
- R8: Opcode 0010 issues one command for every rising clock edge after the second byte, until chip select rises: kind 6 (up) when `spi_si` is 1 and kind 7 (down) when it is 0, for the selected pot.
- R9: While `spi_hold_n` is low, clock edges are ignored, the bit position and shift contents are kept, and `spi_so_oe` is low. When the input returns high, the frame continues from where it stopped.
- R10: A frame whose bit count differs from the length its opcode requires (for example, chip select rising partway through a byte) issues no command.
- R11: Opcodes not listed above issue no command, and `spi_so_oe` stays low for the rest of the frame.
- R12: While `cmd_valid` is high and `cmd_ready` is low, the command payload does not change. A command produced during that time is dropped.
- R13: `spi_so_oe` is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from host |
| spi_hold_n | input | 1 | Active-low pause |
| dev_addr | input | 2 | Strapped device address |
| spi_so | output | 1 | Serial data to host |
| spi_so_oe | output | 1 | Output enable for `spi_so` |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Consumer accepts command |
| cmd_kind | output | 3 | Command kind code (R4, R5, R8) |
| cmd_pot | output | 2 | Selected pot |
| cmd_sel | output | 2 | Selected stored register |
| cmd_data | output | 8 | Write data |
| rd_pot | output | 2 | Pot addressed by a read |
| rd_sel | output | 2 | Stored register addressed by a read |
| rd_wiper | output | 1 | Read targets the wiper register |
| rd_data | input | 8 | Value of the addressed register |
| wr_busy | input | 1 | Nonvolatile write in progress |

## Verification
The bench sweeps all 256 address-byte values and all four strap settings. A decoder that checked only the type nibble, or skipped the two zero bits, would issue commands for foreign frames. All sixteen opcodes are sent at both 16-bit and 24-bit lengths. A decoder that ignored frame length would fire transfers on 24-bit frames or writes on truncated ones, and one that enabled the output too freely would drive `spi_so` for undefined opcodes. Pauses are inserted in mid-byte with clock pulses during the pause. A design that counted those pulses would misalign the data byte or the returned read byte. A stalled consumer is held off across a second frame, which exposes a payload that is overwritten rather than held.

// File: rtl/potctl_pkg.sv
package potctl_pkg;
  localparam int BYTE_W = 8;
  localparam int POT_W  = 2;
  localparam int SEL_W  = 2;
  localparam int OPC_W  = 4;
  localparam int KIND_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_GLB_S2W = 4'b0001,
    OPC_STEP    = 4'b0010,
    OPC_STATUS  = 4'b0101,
    OPC_GLB_W2S = 4'b1000,
    OPC_RD_WIP  = 4'b1001,
    OPC_WR_WIP  = 4'b1010,
    OPC_RD_STO  = 4'b1011,
    OPC_WR_STO  = 4'b1100,
    OPC_S2W     = 4'b1101,
    OPC_W2S     = 4'b1110
  } opc_e;

  typedef enum logic [KIND_W-1:0] {
    K_WR_WIP  = 3'd0,
    K_WR_STO  = 3'd1,
    K_S2W     = 3'd2,
    K_W2S     = 3'd3,
    K_GLB_S2W = 3'd4,
    K_GLB_W2S = 3'd5,
    K_UP      = 3'd6,
    K_DOWN    = 3'd7
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic [POT_W-1:0]   pot;
    logic [SEL_W-1:0]   sel;
    logic [BYTE_W-1:0]  data;
  } cmd_t;
endpackage

// File: rtl/potctl_sync.sv
module potctl_sync #(
  parameter int          N       = 4,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/potctl_frame.sv
module potctl_frame
  import potctl_pkg::*;
#(
  parameter int         ADDR_W    = 2,
  parameter logic [3:0] DEV_TYPE  = 4'b0101,
  parameter int         CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              si,
  input  logic              hold_n,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              link_up,
  output logic              frame_start,
  output logic              sck_fall,
  output logic              instr_vld,
  output logic [BYTE_W-1:0] instr,
  output logic [BYTE_W-1:0] data_byte,
  output logic              id_ok,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              step_ev,
  output logic              step_up,
  output logic              close_ev
);
  localparam int PAD_W = BYTE_W - 4 - ADDR_W;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] END_ID    = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] END_INSTR = CNT_W'(2*BYTE_W - 1);
  localparam logic [CNT_W-1:0] END_DATA  = CNT_W'(3*BYTE_W - 1);
  localparam logic [CNT_W-1:0] AFTER_INSTR = CNT_W'(2*BYTE_W);

  logic              sck_q, csn_q, in_frame, id_bad;
  logic [BYTE_W-1:0] sr, sr_nxt, id_ref;
  logic              cs_fall, cs_rise, sck_rise;

  assign id_ref   = {DEV_TYPE, {PAD_W{1'b0}}, dev_addr};
  assign sr_nxt   = {sr[BYTE_W-2:0], si};
  assign cs_fall  = csn_q & ~csn;
  assign cs_rise  = ~csn_q & csn;
  assign link_up  = in_frame & ~csn & hold_n;
  assign sck_rise = link_up & ~sck_q & sck;
  assign sck_fall = link_up & sck_q & ~sck;
  assign frame_start = cs_fall;
  assign id_ok    = ~id_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      csn_q     <= 1'b0;
      in_frame  <= 1'b0;
      id_bad    <= 1'b0;
      sr        <= '0;
      bit_cnt   <= '0;
      instr     <= '0;
      data_byte <= '0;
      instr_vld <= 1'b0;
      step_ev   <= 1'b0;
      step_up   <= 1'b0;
      close_ev  <= 1'b0;
    end else begin
      sck_q     <= sck;
      csn_q     <= csn;
      instr_vld <= sck_rise && (bit_cnt == END_INSTR) && !id_bad;
      step_ev   <= sck_rise && (bit_cnt >= AFTER_INSTR) && !id_bad;
      step_up   <= si;
      close_ev  <= cs_rise && in_frame;
      if (cs_fall) begin
        in_frame <= 1'b1;
        bit_cnt  <= '0;
        sr       <= '0;
        id_bad   <= 1'b0;
      end else if (cs_rise) begin
        in_frame <= 1'b0;
      end else if (sck_rise) begin
        sr <= sr_nxt;
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == END_ID)    id_bad    <= (sr_nxt != id_ref);
        if (bit_cnt == END_INSTR) instr     <= sr_nxt;
        if (bit_cnt == END_DATA)  data_byte <= sr_nxt;
      end
    end
  end

  a_r9_frozen_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !hold_n) |=> $stable(bit_cnt));
  a_r8_one_step_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> !step_ev);
endmodule

// File: rtl/potctl_cmd.sv
module potctl_cmd
  import potctl_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              frame_start,
  input  logic              sck_fall,
  input  logic              instr_vld,
  input  logic [BYTE_W-1:0] instr,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic              id_ok,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              step_ev,
  input  logic              step_up,
  input  logic              close_ev,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              wr_busy,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output cmd_t              cmd_q,
  output logic [POT_W-1:0]  rd_pot,
  output logic [SEL_W-1:0]  rd_sel,
  output logic              rd_wiper,
  output logic              so,
  output logic              so_oe
);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(2*BYTE_W);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(3*BYTE_W);

  opc_e              opc;
  logic              is_read, tx_en, tx_live, so_q, new_vld;
  logic [BYTE_W-1:0] tx_sr;
  cmd_t              new_cmd;

  assign opc      = opc_e'(instr[BYTE_W-1 -: OPC_W]);
  assign rd_pot   = instr[POT_W-1:0];
  assign rd_sel   = instr[POT_W +: SEL_W];
  assign rd_wiper = (opc == OPC_RD_WIP);
  assign is_read  = (opc == OPC_RD_WIP) || (opc == OPC_RD_STO) || (opc == OPC_STATUS);

  // serial return path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en   <= 1'b0;
      tx_live <= 1'b0;
      tx_sr   <= '0;
      so_q    <= 1'b0;
    end else if (frame_start) begin
      tx_en   <= 1'b0;
      tx_live <= 1'b0;
    end else if (instr_vld) begin
      tx_en <= is_read;
      tx_sr <= (opc == OPC_STATUS) ? {{(BYTE_W-1){1'b0}}, wr_busy} : rd_data;
    end else if (sck_fall && tx_en) begin
      so_q    <= tx_sr[BYTE_W-1];
      tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
      tx_live <= 1'b1;
    end
  end

  assign so    = so_q;
  assign so_oe = tx_live & link_up;

  // command decode
  always_comb begin
    new_vld      = 1'b0;
    new_cmd.kind = K_WR_WIP;
    new_cmd.pot  = instr[POT_W-1:0];
    new_cmd.sel  = instr[POT_W +: SEL_W];
    new_cmd.data = '0;
    if (close_ev && id_ok && bit_cnt == LEN_SHORT) begin
      new_vld = 1'b1;
      case (opc)
        OPC_S2W:     new_cmd.kind = K_S2W;
        OPC_W2S:     new_cmd.kind = K_W2S;
        OPC_GLB_S2W: new_cmd.kind = K_GLB_S2W;
        OPC_GLB_W2S: new_cmd.kind = K_GLB_W2S;
        default:     new_vld = 1'b0;
      endcase
    end else if (close_ev && id_ok && bit_cnt == LEN_LONG) begin
      new_vld      = 1'b1;
      new_cmd.data = data_byte;
      case (opc)
        OPC_WR_WIP: new_cmd.kind = K_WR_WIP;
        OPC_WR_STO: new_cmd.kind = K_WR_STO;
        default:    new_vld = 1'b0;
      endcase
    end else if (step_ev && opc == OPC_STEP) begin
      new_vld      = 1'b1;
      new_cmd.kind = step_up ? K_UP : K_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_q     <= '0;
    end else if (!cmd_valid || cmd_ready) begin
      cmd_valid <= new_vld;
      if (new_vld) cmd_q <= new_cmd;
    end
  end

  a_r12_payload_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_q)));
endmodule

// File: rtl/potctl_spi_decoder.sv
module potctl_spi_decoder
  import potctl_pkg::*;
#(
  parameter int         ADDR_W      = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b0101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [KIND_W-1:0] cmd_kind,
  output logic [POT_W-1:0]  cmd_pot,
  output logic [SEL_W-1:0]  cmd_sel,
  output logic [BYTE_W-1:0] cmd_data,
  output logic [POT_W-1:0]  rd_pot,
  output logic [SEL_W-1:0]  rd_sel,
  output logic              rd_wiper,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              wr_busy
);
  localparam int CNT_W = $clog2(3*BYTE_W + 2);

  logic [3:0]        pins_s;
  logic              sck_s, csn_s, si_s, hold_s;
  logic              link_up, frame_start, sck_fall, instr_vld, id_ok;
  logic              step_ev, step_up, close_ev;
  logic [BYTE_W-1:0] instr, data_byte;
  logic [CNT_W-1:0]  bit_cnt;
  cmd_t              cmd_q;

  // chip select resets low so a pin held low at reset release is no start
  potctl_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .d   ({spi_hold_n, spi_si, spi_csn, spi_sck}),
    .q   (pins_s)
  );
  assign {hold_s, si_s, csn_s, sck_s} = pins_s;

  potctl_frame #(.ADDR_W(ADDR_W), .DEV_TYPE(DEV_TYPE), .CNT_W(CNT_W)) u_frame (
    .clk (clk), .rst_n (rst_n),
    .sck (sck_s), .csn (csn_s), .si (si_s), .hold_n (hold_s),
    .dev_addr (dev_addr),
    .link_up (link_up), .frame_start (frame_start), .sck_fall (sck_fall),
    .instr_vld (instr_vld), .instr (instr), .data_byte (data_byte),
    .id_ok (id_ok), .bit_cnt (bit_cnt),
    .step_ev (step_ev), .step_up (step_up), .close_ev (close_ev)
  );

  potctl_cmd #(.CNT_W(CNT_W)) u_cmd (
    .clk (clk), .rst_n (rst_n),
    .link_up (link_up), .frame_start (frame_start), .sck_fall (sck_fall),
    .instr_vld (instr_vld), .instr (instr), .data_byte (data_byte),
    .id_ok (id_ok), .bit_cnt (bit_cnt),
    .step_ev (step_ev), .step_up (step_up), .close_ev (close_ev),
    .rd_data (rd_data), .wr_busy (wr_busy), .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid), .cmd_q (cmd_q),
    .rd_pot (rd_pot), .rd_sel (rd_sel), .rd_wiper (rd_wiper),
    .so (spi_so), .so_oe (spi_so_oe)
  );

  assign cmd_kind = cmd_q.kind;
  assign cmd_pot  = cmd_q.pot;
  assign cmd_sel  = cmd_q.sel;
  assign cmd_data = cmd_q.data;

  a_r6_drive_after_instr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_so_oe) |-> (bit_cnt >= CNT_W'(2*BYTE_W)));
  a_r13_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |-> !spi_so_oe);
endmodule

// File: tb/potctl_spi_decoder_bench.sv
`timescale 1ns/1ps
module potctl_spi_decoder_bench;
  localparam int H = 5;
  localparam logic [7:0] TYPE_HI = 8'h50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_csn = 1'b0, spi_si = 1'b0, spi_hold_n = 1'b1;
  logic [1:0] dev_addr = 2'b10;
  logic       spi_so, spi_so_oe, cmd_valid;
  logic       cmd_ready = 1'b1;
  logic [2:0] cmd_kind;
  logic [1:0] cmd_pot, cmd_sel, rd_pot, rd_sel;
  logic [7:0] cmd_data, rd_data;
  logic       rd_wiper;
  logic       wr_busy = 1'b0;

  int n_chk = 0, n_err = 0;
  int n_cmd = 0, n_up = 0, n_dn = 0;
  int last_kind = -1, last_pot = -1, last_sel = -1, last_data = -1;
  logic [7:0] rx;
  bit oe_seen, hold_oe;

  always #4 clk = ~clk;

  potctl_spi_decoder u_potctl_spi_decoder (
    .clk, .rst_n, .spi_sck, .spi_csn, .spi_si, .spi_hold_n, .dev_addr,
    .spi_so, .spi_so_oe, .cmd_valid, .cmd_ready, .cmd_kind, .cmd_pot,
    .cmd_sel, .cmd_data, .rd_pot, .rd_sel, .rd_wiper, .rd_data, .wr_busy
  );

  function automatic logic [7:0] reg_model(input logic [1:0] p, input logic [1:0] r, input logic w);
    return w ? 8'h40 + 8'(p) * 8'h15 : 8'h81 + 8'({p, r}) * 8'h0B;
  endfunction
  assign rd_data = reg_model(rd_pot, rd_sel, rd_wiper);

  always @(posedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      n_cmd++;
      last_kind = cmd_kind; last_pot = cmd_pot; last_sel = cmd_sel; last_data = cmd_data;
      if (cmd_kind == 3'd6) n_up++;
      if (cmd_kind == 3'd7) n_dn++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pause_episode();
    spi_hold_n = 1'b0;
    repeat (H) @(negedge clk);
    if (spi_so_oe) hold_oe = 1'b1;
    for (int k = 0; k < 3; k++) begin
      spi_si = ~spi_si; spi_sck = 1'b1;
      repeat (H) @(negedge clk);
      if (spi_so_oe) hold_oe = 1'b1;
      spi_sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    spi_hold_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic do_frame(input logic [31:0] bits, input int nbits, input int hold_at);
    oe_seen = 1'b0; hold_oe = 1'b0; rx = '0;
    spi_csn = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i == hold_at) pause_episode();
      spi_si = bits[nbits-1-i];
      for (int k = 0; k < H; k++) begin
        @(negedge clk);
        if (spi_so_oe) oe_seen = 1'b1;
      end
      if (i >= 16 && i < 24) rx = {rx[6:0], spi_so};
      spi_sck = 1'b1;
      repeat (H) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (H) @(negedge clk);
    spi_csn = 1'b1;
    repeat (3*H) @(negedge clk);
  endtask

  function automatic int exp_kind(input int op, input int len);
    if (len == 16) begin
      case (op) 13: return 2; 14: return 3; 1: return 4; 8: return 5; default: return -1; endcase
    end
    case (op) 10: return 0; 12: return 1; default: return -1; endcase
  endfunction

  initial begin
    int base;
    logic [7:0] idb;
    idb = TYPE_HI | 8'h02;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 reset cmd_valid", cmd_valid, 0);
    chk(spi_so_oe == 1'b0, "R1 reset so_oe", spi_so_oe, 0);

    // R1: chip select low since reset, no falling edge
    do_frame({8'h00, idb, 8'hA1, 8'h77}, 24, -1);
    chk(n_cmd == 0, "R1 no start edge", n_cmd, 0);

    // R2: every address byte value
    for (int id = 0; id < 256; id++) begin
      base = n_cmd;
      do_frame({8'h00, 8'(id), 6'b101000, 2'(id), 8'(id) ^ 8'h5A}, 24, -1);
      if (id == 8'h52) begin
        chk(n_cmd - base == 1, "R2 matching id", n_cmd - base, 1);
        chk(last_data == (8'h52 ^ 8'h5A) && last_kind == 0, "R5 wiper write data", last_data, 8'h52 ^ 8'h5A);
      end else begin
        chk(n_cmd == base, "R2 foreign id", n_cmd - base, 0);
      end
    end
    for (int a = 0; a < 4; a++) begin
      dev_addr = 2'(a);
      base = n_cmd;
      do_frame({8'h00, idb, 8'hC6, 8'h3E}, 24, -1);
      chk(n_cmd - base == ((a == 2) ? 1 : 0), "R2 strap compare", n_cmd - base, (a == 2) ? 1 : 0);
    end
    dev_addr = 2'b10;

    // R3 R4 R5 R11: opcode sweep at both lengths
    for (int op = 0; op < 16; op++) begin
      for (int ln = 16; ln <= 24; ln += 8) begin
        logic [7:0] ins;
        int ek, ecount;
        ins = {4'(op), 2'(op), ~2'(op)};
        base = n_cmd;
        if (ln == 16) do_frame({16'h0, idb, ins}, 16, -1);
        else          do_frame({8'h0, idb, ins, 8'h5A ^ 8'(op)}, 24, -1);
        ek = exp_kind(op, ln);
        ecount = (op == 2 && ln == 24) ? 8 : ((ek >= 0) ? 1 : 0);
        chk(n_cmd - base == ecount, "R4 R5 R10 opcode count", n_cmd - base, ecount);
        if (ek >= 0) begin
          chk(last_kind == ek, "R4 R5 kind", last_kind, ek);
          chk(last_pot == int'(ins[1:0]) && last_sel == int'(ins[3:2]), "R3 fields", {last_sel, last_pot}, {ins[3:2], ins[1:0]});
          if (ln == 24) chk(last_data == int'(8'h5A ^ 8'(op)), "R5 data", last_data, 8'h5A ^ 8'(op));
        end
        if (!(op == 9 || op == 11 || op == 5)) chk(!oe_seen, "R11 so quiet", oe_seen, 0);
        else if (ln == 24) chk(oe_seen, "R6 so driven", oe_seen, 1);
      end
    end

    // R6: reads of every register
    for (int p = 0; p < 4; p++) begin
      do_frame({8'h0, idb, 4'b1001, 2'b00, 2'(p), 8'h00}, 24, -1);
      chk(rx == reg_model(2'(p), 2'b00, 1'b1), "R6 wiper read", rx, reg_model(2'(p), 2'b00, 1'b1));
      for (int r = 0; r < 4; r++) begin
        do_frame({8'h0, idb, 4'b1011, 2'(r), 2'(p), 8'h00}, 24, -1);
        chk(rx == reg_model(2'(p), 2'(r), 1'b0), "R6 stored read", rx, reg_model(2'(p), 2'(r), 1'b0));
      end
    end
    chk(spi_so_oe == 1'b0, "R13 deselected", spi_so_oe, 0);

    // R7: status
    for (int b = 0; b < 2; b++) begin
      wr_busy = 1'(b);
      do_frame({8'h0, idb, 8'h51, 8'h00}, 24, -1);
      chk(rx == 8'(b), "R7 status byte", rx, b);
    end
    wr_busy = 1'b0;

    // R8: step stream 1101000 on pot 3
    base = n_cmd;
    begin
      int u0, d0;
      u0 = n_up; d0 = n_dn;
      do_frame({9'h0, idb, 8'h23, 7'b1101000}, 23, -1);
      chk(n_up - u0 == 3, "R8 up steps", n_up - u0, 3);
      chk(n_dn - d0 == 4, "R8 down steps", n_dn - d0, 4);
      chk(last_pot == 3 && last_kind == 7, "R8 last step", last_kind, 7);
    end

    // R9: pause in mid-byte
    base = n_cmd;
    do_frame({8'h0, idb, 8'hA1, 8'hE4}, 24, 10);
    chk(n_cmd - base == 1 && last_data == 8'hE4, "R9 write across pause", last_data, 8'hE4);
    do_frame({8'h0, idb, 8'h9B, 8'h00}, 24, 19);
    chk(rx == reg_model(2'b11, 2'b10, 1'b1), "R9 read across pause", rx, reg_model(2'b11, 2'b10, 1'b1));
    chk(!hold_oe, "R9 so released in pause", hold_oe, 0);

    // R10: wrong lengths
    base = n_cmd;
    do_frame({12'h0, idb, 8'hA1, 4'h7}, 20, -1);
    do_frame({20'h0, idb, 4'hD}, 12, -1);
    do_frame({7'h0, idb, 8'hA1, 8'h33, 1'b0}, 25, -1);
    do_frame({15'h0, idb, 8'hE2, 1'b1}, 17, -1);
    chk(n_cmd == base, "R10 bad length", n_cmd - base, 0);

    // R12: stalled consumer
    cmd_ready = 1'b0;
    do_frame({8'h0, idb, 8'hA1, 8'hC3}, 24, -1);
    chk(cmd_valid && cmd_data == 8'hC3, "R12 pending", cmd_data, 8'hC3);
    do_frame({8'h0, idb, 8'hA2, 8'h3C}, 24, -1);
    chk(cmd_valid && cmd_data == 8'hC3 && cmd_pot == 2'd1, "R12 held payload", cmd_data, 8'hC3);
    base = n_cmd;
    cmd_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(n_cmd - base == 1 && last_data == 8'hC3, "R12 single accept", n_cmd - base, 1);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule